// File: doc/BRIEF.md
# BCH NAND Sector Parity Generator

This block computes the BCH check bits that protect each 512-byte sector of a NAND page. Data bytes stream in over a valid/ready byte port. The block divides the sector by the code's generator polynomial, keeps the remainder, and then presents the result as a short run of parity bytes that the controller writes into the spare area. The code is built over GF(2^13), and the field is defined by the primitive polynomial 0x201B. A parameter selects the correction strength: 4 bits per sector gives a 52-bit remainder, and 8 bits per sector gives a 104-bit remainder.

A start pulse clears the block and opens a page of four sectors. For each sector the block accepts 512 bytes and then freezes the remainder. It left-justifies the remainder into whole bytes and XORs each byte with a fixed constant, so that an erased sector of all-ones data produces all-ones parity. It then hands the bytes out one per read strobe. Once the last parity byte of a sector has been read, the block opens the next sector. After the fourth sector it returns to idle until the next start pulse.

Top module: `bch_sector_parity`

## Requirements
- R1: After reset, `in_ready` and `done` are both low, and no byte is accepted until `start` is pulsed.
- R2: A `start` pulse clears the remainder and the counters in any state, and raises `in_ready` on the next cycle; bytes taken before a mid-sector `start` have no effect on the parity that follows.
- R3: A byte is absorbed only on a cycle where `in_valid` and `in_ready` are both high; idle cycles between bytes do not change the result.
- R4: The cycle after the 512th byte is accepted, `in_ready` is low and `done` is high. The parity equals the remainder of data(x)·x^P modulo g(x), where P is 52 or 104 and g(x) is the product of the minimal polynomials of α^1, α^3, …, α^(2t−1) over GF(2^13) with field polynomial 0x201B. Data bits enter bit 7 first within each byte, in byte order.
- R5: With T_CORR=4, the parity is 7 bytes: the 52 remainder bits, most significant first, then four zero bits. Byte k is XORed with mask k from the list 28 13 CC 39 96 AC 7F (hex, k=0 first).
- R6: With T_CORR=8, the parity is 13 bytes of remainder, most significant first. Byte k is XORed with mask k from the list EF 51 2E 09 ED 93 9A C2 97 79 E5 24 B5 (hex, k=0 first).
- R7: While `done` is high, `par_data` shows the current byte. A cycle with `par_rd` high steps to the next byte, and a cycle without it holds `par_data` unchanged.
- R8: `par_last` is high only while the final parity byte of a sector is shown. Reading that byte drops `done` on the next cycle.
- R9: `sec_idx` gives the sector (0 to 3) whose parity is being read. After sector 3 has been read, the block is idle, with `in_ready` and `done` both low.
- R10: A sector of 512 bytes of 0xFF yields parity bytes that are all 0xFF in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Single-cycle pulse that opens a new page |
| in_valid | input | 1 | Data byte present |
| in_data | input | 8 | Sector data byte |
| in_ready | output | 1 | Block can accept a data byte |
| done | output | 1 | Parity of the current sector is ready to read |
| par_data | output | 8 | Current masked parity byte |
| par_last | output | 1 | Current parity byte is the last of the sector |
| par_rd | input | 1 | Read strobe, consumes the current parity byte |
| sec_idx | output | 2 | Sector number within the page |

## Verification
A corrupted remainder stays invisible while the sector is being filled. It appears only in the parity bytes, one cycle after the 512th byte is taken, so every sector is compared byte by byte against a bit-serial division model in both strengths. A miscounted byte counter shows up as `done` rising one or more cycles early or late. A wrong read index shows up at the first parity byte, as a mask applied to the wrong byte or as `par_last` in the wrong place. A broken sector counter appears only at the fourth sector, where the block must fall idle.

// File: rtl/bch_par_pkg.sv
// Package: shared constants, field arithmetic and generator construction
// for the BCH sector parity generator. The generator polynomial is derived
// at elaboration time from the field polynomial, so no table is written out.
package bch_par_pkg;

    localparam int          GF_M       = 13;
    localparam int          GF_ORDER   = 8191;
    localparam logic [13:0] FIELD_POLY = 14'h201B;
    localparam int          MAX_PAR_W  = 104;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_t;

    // Erased-sector masks, one list per strength, byte 0 first.
    localparam logic [0:6][7:0]  MASK_T4 = {8'h28, 8'h13, 8'hCC, 8'h39,
                                            8'h96, 8'hAC, 8'h7F};
    localparam logic [0:12][7:0] MASK_T8 = {8'hEF, 8'h51, 8'h2E, 8'h09,
                                            8'hED, 8'h93, 8'h9A, 8'hC2,
                                            8'h97, 8'h79, 8'hE5, 8'h24,
                                            8'hB5};

    // Multiply two GF(2^13) elements, reducing by the field polynomial.
    function automatic logic [12:0] gf_mul(input logic [12:0] a,
                                           input logic [12:0] b);
        logic [13:0] sh;
        logic [12:0] acc;
        acc = '0;
        sh  = {1'b0, a};
        for (int i = 0; i < GF_M; i++) begin
            if (b[i]) acc ^= sh[12:0];
            sh = sh << 1;
            if (sh[13]) sh ^= FIELD_POLY;
        end
        return acc;
    endfunction

    // Binary generator polynomial: product of the minimal polynomials of
    // alpha^i for odd i below 2t, each cyclotomic coset taken once.
    function automatic logic [104:0] gen_poly(input int t);
        logic [104:0]      g;
        logic [104:0]      prod;
        logic [13:0][12:0] c;
        logic [12:0]       root;
        int                e;
        int                mn;
        g = 105'd1;
        for (int i = 1; i < 2 * t; i += 2) begin
            e  = i;
            mn = i;
            for (int j = 0; j < GF_M; j++) begin
                e = (e * 2) % GF_ORDER;
                if (e < mn) mn = e;
            end
            if (mn == i) begin
                root = 13'd1;
                for (int k = 0; k < i; k++) root = gf_mul(root, 13'd2);
                c    = '0;
                c[0] = 13'd1;
                for (int j = 0; j < GF_M; j++) begin
                    for (int k = GF_M; k >= 1; k--)
                        c[k] = c[k-1] ^ gf_mul(c[k], root);
                    c[0] = gf_mul(c[0], root);
                    root = gf_mul(root, root);
                end
                prod = '0;
                for (int k = 0; k <= GF_M; k++)
                    if (c[k][0]) prod ^= (g << k);
                g = prod;
            end
        end
        return g;
    endfunction

endpackage

// File: rtl/bch_byte_lfsr.sv
// Module: byte-parallel polynomial divider.
// Absorbs one data byte per enabled cycle, bit 7 first, into a PAR_W-bit
// remainder of data(x)*x^PAR_W mod g(x). Assumes GEN_LOW holds g(x) without
// its leading term. The next remainder is exported so that a caller can
// capture it on the same edge as the final byte.
module bch_byte_lfsr #(
    parameter int               PAR_W   = 104,
    parameter logic [PAR_W-1:0] GEN_LOW = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic [7:0]       din,
    output logic [PAR_W-1:0] rem_next
);

    logic [PAR_W-1:0] rem_q;
    logic [PAR_W-1:0] work;
    logic             fb;

    // Unroll eight serial division steps into one cycle.
    always_comb begin
        work = rem_q;
        fb   = 1'b0;
        for (int b = 7; b >= 0; b--) begin
            fb   = din[b] ^ work[PAR_W-1];
            work = {work[PAR_W-2:0], 1'b0} ^ (fb ? GEN_LOW : '0);
        end
        rem_next = work;
    end

    // Remainder register: cleared on request, advanced per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) rem_q <= '0;
        else if (shift_en)   rem_q <= rem_next;
    end

endmodule

// File: rtl/bch_sector_seq.sv
// Module: sector and page sequencer.
// Counts accepted bytes per sector, switches between filling and draining,
// walks the parity read index and steps through the sectors of a page.
// Assumes SECTORS >= 2 and NBYTES >= 2.
module bch_sector_seq
    import bch_par_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int SECTORS      = 4,
    parameter int NBYTES       = 13,
    localparam int CNT_W       = $clog2(SECTOR_BYTES),
    localparam int IDX_W       = $clog2(NBYTES),
    localparam int SEC_W       = $clog2(SECTORS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             in_valid,
    input  logic             par_rd,
    output logic             in_ready,
    output logic             done,
    output logic             lfsr_clear,
    output logic             lfsr_shift,
    output logic             freeze,
    output logic             out_shift,
    output logic             par_last,
    output logic [IDX_W-1:0] rd_idx,
    output logic [SEC_W-1:0] sec_idx
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SECTOR_BYTES - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);
    localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(SECTORS - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] byte_cnt;
    logic             accept;
    logic             last_byte;
    logic             rd_ok;

    // Handshake and control strobes decoded from the state.
    always_comb begin
        in_ready   = (state == ST_FILL);
        done       = (state == ST_DRAIN);
        accept     = in_ready && in_valid;
        last_byte  = (byte_cnt == LAST_CNT);
        freeze     = accept && last_byte;
        lfsr_shift = accept && !last_byte;
        lfsr_clear = start || freeze;
        rd_ok      = done && par_rd;
        out_shift  = rd_ok;
        par_last   = done && (rd_idx == LAST_IDX);
    end

    // State, byte counter, read index and sector counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            byte_cnt <= '0;
            rd_idx   <= '0;
            sec_idx  <= '0;
        end else if (start) begin
            state    <= ST_FILL;
            byte_cnt <= '0;
            rd_idx   <= '0;
            sec_idx  <= '0;
        end else begin
            case (state)
                ST_FILL: begin
                    if (accept) begin
                        if (last_byte) begin
                            state    <= ST_DRAIN;
                            byte_cnt <= '0;
                            rd_idx   <= '0;
                        end else begin
                            byte_cnt <= byte_cnt + 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (rd_ok) begin
                        if (rd_idx == LAST_IDX) begin
                            rd_idx <= '0;
                            if (sec_idx == LAST_SEC) begin
                                state   <= ST_IDLE;
                                sec_idx <= '0;
                            end else begin
                                state   <= ST_FILL;
                                sec_idx <= sec_idx + 1'b1;
                            end
                        end else begin
                            rd_idx <= rd_idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bch_parity_drain.sv
// Module: parity output stage.
// Captures the left-justified remainder when a sector completes, shifts it
// out one byte per read, and XORs the visible byte with the mask chosen by
// the correction strength and the read index.
module bch_parity_drain
    import bch_par_pkg::*;
#(
    parameter int T_CORR = 8,
    localparam int PAR_W  = 13 * T_CORR,
    localparam int NBYTES = (PAR_W + 7) / 8,
    localparam int PAD_W  = NBYTES * 8 - PAR_W,
    localparam int IDX_W  = $clog2(NBYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze,
    input  logic             out_shift,
    input  logic [PAR_W-1:0] rem_in,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       par_data
);

    logic [NBYTES*8-1:0] padded;
    logic [NBYTES*8-1:0] hold;
    logic [7:0]          mask_byte;

    // Left-justify the remainder, with zero padding only when needed.
    generate
        if (PAD_W > 0) begin : g_pad
            assign padded = {rem_in, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign padded = rem_in;
        end
    endgenerate

    // Mask list picked by strength.
    generate
        if (T_CORR == 4) begin : g_mask4
            assign mask_byte = MASK_T4[rd_idx];
        end else begin : g_mask8
            assign mask_byte = MASK_T8[rd_idx];
        end
    endgenerate

    // Parity hold register: load on freeze, shift a byte per read.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold <= '0;
        else if (freeze)    hold <= padded;
        else if (out_shift) hold <= hold << 8;
    end

    // Visible byte is the top of the hold register, masked.
    assign par_data = hold[NBYTES*8-1 -: 8] ^ mask_byte;

endmodule

// File: rtl/bch_sector_parity.sv
// Module: top of the BCH sector parity generator.
// Streams the bytes of one page through a byte-parallel divider, then
// presents each sector's masked parity for reading. T_CORR selects 4 or 8
// bit correction; the generator is computed from it at elaboration.
module bch_sector_parity
    import bch_par_pkg::*;
#(
    parameter int T_CORR       = 8,
    parameter int SECTOR_BYTES = 512,
    parameter int SECTORS      = 4,
    localparam int PAR_W       = 13 * T_CORR,
    localparam int NBYTES      = (PAR_W + 7) / 8,
    localparam int IDX_W       = $clog2(NBYTES),
    localparam int SEC_W       = $clog2(SECTORS),
    localparam logic [104:0]     GEN_FULL = gen_poly(T_CORR),
    localparam logic [PAR_W-1:0] GEN_LOW  = GEN_FULL[PAR_W-1:0]
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             done,
    output logic [7:0]       par_data,
    output logic             par_last,
    input  logic             par_rd,
    output logic [SEC_W-1:0] sec_idx
);

    logic             lfsr_clear;
    logic             lfsr_shift;
    logic             freeze;
    logic             out_shift;
    logic [IDX_W-1:0] rd_idx;
    logic [PAR_W-1:0] rem_next;

    bch_sector_seq #(
        .SECTOR_BYTES(SECTOR_BYTES),
        .SECTORS     (SECTORS),
        .NBYTES      (NBYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_valid  (in_valid),
        .par_rd    (par_rd),
        .in_ready  (in_ready),
        .done      (done),
        .lfsr_clear(lfsr_clear),
        .lfsr_shift(lfsr_shift),
        .freeze    (freeze),
        .out_shift (out_shift),
        .par_last  (par_last),
        .rd_idx    (rd_idx),
        .sec_idx   (sec_idx)
    );

    bch_byte_lfsr #(
        .PAR_W  (PAR_W),
        .GEN_LOW(GEN_LOW)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (lfsr_clear),
        .shift_en(lfsr_shift),
        .din     (in_data),
        .rem_next(rem_next)
    );

    bch_parity_drain #(
        .T_CORR(T_CORR)
    ) u_drain (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze   (freeze),
        .out_shift(out_shift),
        .rem_in   (rem_next),
        .rd_idx   (rd_idx),
        .par_data (par_data)
    );

endmodule

// File: rtl/bch_sector_parity_chk.sv
// Checker: port-level temporal rules of the parity generator, bound to
// every instance of the top module.
module bch_sector_parity_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       in_ready,
    input logic       done,
    input logic [7:0] par_data,
    input logic       par_last,
    input logic       par_rd
);

    // R4: accepting and draining never overlap.
    p_fill_drain_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && done));

    // R2: a start pulse always leads to the accepting state.
    p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (in_ready && !done));

    // R7: without a read the shown parity byte holds.
    p_hold_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !par_rd && !start) |=> (done && $stable(par_data)));

    // R8: the last-byte flag only appears while draining.
    p_last_in_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        par_last |-> done);

    // R8: consuming the last byte ends the drain.
    p_last_read_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (par_last && par_rd && !start) |=> !done);

endmodule

bind bch_sector_parity bch_sector_parity_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .in_ready(in_ready),
    .done    (done),
    .par_data(par_data),
    .par_last(par_last),
    .par_rd  (par_rd)
);

// File: tb/bch_sector_parity_tb.sv
// Directed bench: one instance per strength, shared input stream, parity
// compared against a bit-serial division model.
module bch_sector_parity_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       rd8 = 1'b0;
    logic       rd4 = 1'b0;
    logic       in_ready8, in_ready4, done8, done4, last8, last4;
    logic [7:0] par8, par4;
    logic [1:0] sec8, sec4;

    int checks = 0;
    int errors = 0;
    logic [7:0] sector_buf [0:511];

    always #(CLK_PERIOD/2) clk = ~clk;

    bch_sector_parity #(.T_CORR(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready8), .done(done8),
        .par_data(par8), .par_last(last8), .par_rd(rd8), .sec_idx(sec8));

    bch_sector_parity #(.T_CORR(4)) u_dut4 (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready4), .done(done4),
        .par_data(par4), .par_last(last4), .par_rd(rd4), .sec_idx(sec4));

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input int t, input int k);
        logic [0:6][7:0]  m4 = {8'h28, 8'h13, 8'hCC, 8'h39, 8'h96, 8'hAC, 8'h7F};
        logic [0:12][7:0] m8 = {8'hEF, 8'h51, 8'h2E, 8'h09, 8'hED, 8'h93, 8'h9A,
                                8'hC2, 8'h97, 8'h79, 8'hE5, 8'h24, 8'hB5};
        return (t == 4) ? m4[k] : m8[k];
    endfunction

    // Bit-serial division of the buffered sector by g(x).
    function automatic logic [103:0] ref_rem(input int t);
        logic [104:0] g;
        logic [103:0] lowm;
        logic [103:0] r;
        logic         fb;
        int           pw;
        pw   = 13 * t;
        g    = bch_par_pkg::gen_poly(t);
        lowm = {104{1'b1}} >> (104 - pw);
        r    = '0;
        for (int i = 0; i < 512; i++) begin
            for (int b = 7; b >= 0; b--) begin
                fb = sector_buf[i][b] ^ r[pw-1];
                r  = (r << 1) & lowm;
                if (fb) r ^= (g[103:0] & lowm);
            end
        end
        return r;
    endfunction

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 in_ready after start", {31'd0, in_ready8 & in_ready4}, 32'd1);
    endtask

    // Feed 'count' bytes of the buffer, optionally with idle cycles.
    task automatic feed(input int count, input bit gaps);
        int i = 0;
        int cyc = 0;
        while (i < count) begin
            @(negedge clk);
            if (gaps && (cyc % 3 == 1)) begin
                in_valid = 1'b0;
                in_data  = 8'hA5;
            end else begin
                in_valid = 1'b1;
                in_data  = sector_buf[i];
                if (in_ready8) i++;
            end
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Read one instance's parity and compare; entered just after a negedge.
    task automatic drain_check(input int t, input int sec, input bit erased,
                               input string tag);
        logic [103:0] pv;
        logic [7:0]   held;
        int           nb;
        nb = (t == 4) ? 7 : 13;
        pv = ref_rem(t) << (nb * 8 - 13 * t);
        chk({tag, " R4 done"}, {31'd0, (t == 4) ? done4 : done8}, 32'd1);
        chk({tag, " R4 in_ready low"}, {31'd0, (t == 4) ? in_ready4 : in_ready8}, 32'd0);
        chk({tag, " R9 sec_idx"}, {30'd0, (t == 4) ? sec4 : sec8}, sec);
        held = (t == 4) ? par4 : par8;
        @(negedge clk);
        chk({tag, " R7 hold"}, {24'd0, (t == 4) ? par4 : par8}, {24'd0, held});
        for (int k = 0; k < nb; k++) begin
            chk({tag, (t == 4) ? " R5 byte" : " R6 byte"},
                {24'd0, (t == 4) ? par4 : par8},
                {24'd0, pv[nb*8-1-8*k -: 8] ^ mask_of(t, k)});
            chk({tag, " R8 par_last"}, {31'd0, (t == 4) ? last4 : last8},
                {31'd0, (k == nb - 1)});
            if (erased)
                chk({tag, " R10 erased"}, {24'd0, (t == 4) ? par4 : par8}, 32'hFF);
            if (t == 4) rd4 = 1'b1; else rd8 = 1'b1;
            @(negedge clk);
        end
        rd4 = 1'b0;
        rd8 = 1'b0;
        chk({tag, " R8 done drops"}, {31'd0, (t == 4) ? done4 : done8}, 32'd0);
    endtask

    task automatic run_sector(input int sec, input bit gaps, input bit erased,
                              input string tag);
        feed(512, gaps);
        drain_check(8, sec, erased, tag);
        drain_check(4, sec, erased, tag);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        chk("R1 in_ready after reset", {31'd0, in_ready8 | in_ready4}, 32'd0);
        chk("R1 done after reset", {31'd0, done8 | done4}, 32'd0);
        in_valid = 1'b0;
    endtask

    task automatic test_page();
        pulse_start();
        for (int i = 0; i < 512; i++) sector_buf[i] = 8'hFF;
        run_sector(0, 1'b0, 1'b1, "erased");
        for (int i = 0; i < 512; i++) sector_buf[i] = 8'h00;
        run_sector(1, 1'b0, 1'b0, "zeros");
        for (int i = 0; i < 512; i++) sector_buf[i] = 8'($urandom);
        run_sector(2, 1'b1, 1'b0, "R3 gaps");
        for (int i = 0; i < 512; i++) sector_buf[i] = 8'(i * 7 + 3);
        run_sector(3, 1'b0, 1'b0, "ramp");
        @(negedge clk);
        chk("R9 idle in_ready", {31'd0, in_ready8 | in_ready4}, 32'd0);
        chk("R9 idle done", {31'd0, done8 | done4}, 32'd0);
    endtask

    task automatic test_restart();
        pulse_start();
        for (int i = 0; i < 512; i++) sector_buf[i] = 8'h3C ^ 8'(i);
        feed(100, 1'b0);
        pulse_start();
        for (int i = 0; i < 512; i++) sector_buf[i] = 8'($urandom);
        run_sector(0, 1'b0, 1'b0, "R2 restart");
    endtask

    initial begin
        test_reset();
        test_page();
        test_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule